// File: doc/BRIEF.md
# Processor Power-Up Sequencer

This block brings a processor subsystem out of reset by stepping its control bits through a fixed order. It drives three control words: the reset bits, the power-control bits and the clock-mux enable. A one-cycle pulse on `start_i` runs the whole order, and `done_o` rises once the core has been released to execute. The order is as follows. The resets are asserted first. The power headswitch and LDO bypass are then turned on, and the sequencer waits a settling window. Next the memory retention and standby group is switched on, followed by the L2 data banks one at a time, highest bank first, so that inrush current stays low. After that the IO clamp is released, the core reset is removed, the core clock is enabled and stop-core is cleared.

`pwrdn_i` can be raised at any time. It returns every control bit to its reset value in one cycle and makes the block ready to be started again. The block drives only the control bits. Supplies, clocks and register access are handled elsewhere.

Top module: `core_powerup_seq`

## Requirements
- R1: After reset, or while idle without a start, the outputs hold these values: `rst_ctl_o` = 3'b111 (bit 0 stop-core, bit 1 core reset, bit 2 bus reset), `clk_ctl_o` = 2'b00 (bit 1 core clock enable), `pwr_ctl_o` has only bit 20 (IO clamp) set, and `done_o` = 0.
- R2: On the clock edge that samples `start_i` high in idle, all three reset bits are driven set. On the next edge, headswitch (bit 22-1 = 21) and LDO bypass (bit 22) are set in `pwr_ctl_o`.
- R3: The retention group is set together exactly SETTLE_CYC edges after the headswitch edge, and none of it is set earlier. The group is L2 tag (bit 16), trace buffer (bit 17), L2 standby (bit 18) and sleep retention (bit 19).
- R4: The L2 data bank enables (bits NB_L2-1..0) are set one per edge on the edges following the retention group, starting at bank NB_L2-1 and ending at bank 0. No two banks are set on the same edge.
- R5: The IO clamp (bit 20) is cleared on the edge after bank 0 is enabled, and this happens while core reset is still asserted.
- R6: On the three edges after the clamp is released, the following happen in order: core reset clears, then the core clock enable is set, then stop-core clears. The bus reset bit stays set throughout.
- R7: `done_o` rises on the same edge that stop-core clears, and it stays high until power-down.
- R8: `start_i` has no effect while a sequence is running or after it has completed.
- R9: When `pwrdn_i` is sampled high in any state, all outputs return to their R1 values on that edge. It takes priority over `start_i`, and a later start runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the power-up order (sampled in idle) |
| pwrdn_i | input | 1 | Return all control bits to reset values |
| rst_ctl_o | output | 3 | Reset control bits: stop-core, core reset, bus reset |
| clk_ctl_o | output | 2 | Clock-mux control, bit 1 is core clock enable |
| pwr_ctl_o | output | 23 | Power-control bits: banks, retention, clamp, headswitch, LDO bypass |
| done_o | output | 1 | Core released and running |

## Verification
The bench runs an uninterrupted sequence with `start_i` held low between steps. This confirms the exact edge of every step against the settle count and the bank order. It also runs a sequence where `start_i` pulses repeatedly mid-sequence and after completion, which separates a block that correctly ignores start from one that restarts or re-enters. Power-down is applied during the settle window, in the done state, and in the same cycle as a start. These cases show that the timer and the step state are both cleared, and that power-down wins the tie. A restart after each power-down then shows that the order is reproduced in full.

// File: rtl/pup_pkg.sv
package pup_pkg;
  localparam int RST_W = 3;
  localparam int CLK_W = 2;
  localparam int PWR_W = 23;

  localparam int RB_STOP = 0;
  localparam int RB_CORE = 1;
  localparam int RB_BUS  = 2;
  localparam int CB_EN   = 1;

  localparam int PB_TAG    = 16;
  localparam int PB_ETB    = 17;
  localparam int PB_STBY   = 18;
  localparam int PB_SLPRET = 19;
  localparam int PB_CLAMP  = 20;
  localparam int PB_HS     = 21;
  localparam int PB_LDO    = 22;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HS, ST_WAIT, ST_BANK, ST_UNCLAMP,
    ST_CORE, ST_CLK, ST_GO, ST_DONE
  } st_e;

  typedef enum logic [3:0] {
    A_NONE, A_OFF, A_RESET, A_HS, A_MEM, A_BANK,
    A_UNCLAMP, A_CORE, A_CLK, A_GO
  } act_e;
endpackage

// File: rtl/pup_timer.sv
module pup_timer #(
  parameter int SETTLE_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  output logic exp_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign exp_o = run_q && (cnt_q == CNT_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (exp_o) run_q <= 1'b0;
      else       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pup_fsm.sv
module pup_fsm
  import pup_pkg::*;
#(
  parameter int NB_L2 = 3,
  localparam int BW = (NB_L2 > 1) ? $clog2(NB_L2) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          pwrdn_i,
  input  logic          tmr_exp_i,
  output logic          tmr_load_o,
  output act_e          act_o,
  output logic [BW-1:0] bank_o,
  output logic          done_o
);
  st_e           st_q, st_d;
  logic [BW-1:0] bk_q, bk_d;

  always_comb begin
    st_d       = st_q;
    bk_d       = bk_q;
    act_o      = A_NONE;
    tmr_load_o = 1'b0;
    if (pwrdn_i) begin
      act_o = A_OFF;
      st_d  = ST_IDLE;
      bk_d  = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          act_o = A_RESET;
          st_d  = ST_HS;
        end
        ST_HS: begin
          act_o      = A_HS;
          tmr_load_o = 1'b1;
          st_d       = ST_WAIT;
        end
        ST_WAIT: if (tmr_exp_i) begin
          act_o = A_MEM;
          bk_d  = BW'(NB_L2 - 1);
          st_d  = ST_BANK;
        end
        ST_BANK: begin
          act_o = A_BANK;
          if (bk_q == '0) st_d = ST_UNCLAMP;
          else            bk_d = bk_q - 1'b1;
        end
        ST_UNCLAMP: begin act_o = A_UNCLAMP; st_d = ST_CORE; end
        ST_CORE:    begin act_o = A_CORE;    st_d = ST_CLK;  end
        ST_CLK:     begin act_o = A_CLK;     st_d = ST_GO;   end
        ST_GO:      begin act_o = A_GO;      st_d = ST_DONE; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      bk_q <= '0;
    end else begin
      st_q <= st_d;
      bk_q <= bk_d;
    end
  end

  assign bank_o = bk_q;
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/pup_ctl_regs.sv
module pup_ctl_regs
  import pup_pkg::*;
#(
  parameter int NB_L2 = 3,
  localparam int BW = (NB_L2 > 1) ? $clog2(NB_L2) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  input  logic [BW-1:0]    bank_i,
  output logic [RST_W-1:0] rst_ctl_o,
  output logic [CLK_W-1:0] clk_ctl_o,
  output logic [PWR_W-1:0] pwr_ctl_o
);
  logic [RST_W-1:0] rst_q;
  logic             clk_en_q;
  logic             hs_q, ldo_q, mem_q, clamp_q;
  logic [NB_L2-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q    <= '1;
      clk_en_q <= 1'b0;
      hs_q     <= 1'b0;
      ldo_q    <= 1'b0;
      mem_q    <= 1'b0;
      clamp_q  <= 1'b1;
    end else begin
      unique case (act_i)
        A_OFF: begin
          rst_q    <= '1;
          clk_en_q <= 1'b0;
          hs_q     <= 1'b0;
          ldo_q    <= 1'b0;
          mem_q    <= 1'b0;
          clamp_q  <= 1'b1;
        end
        A_RESET:   rst_q <= '1;
        A_HS:      begin hs_q <= 1'b1; ldo_q <= 1'b1; end
        A_MEM:     mem_q <= 1'b1;
        A_UNCLAMP: clamp_q <= 1'b0;
        A_CORE:    rst_q[RB_CORE] <= 1'b0;
        A_CLK:     clk_en_q <= 1'b1;
        A_GO:      rst_q[RB_STOP] <= 1'b0;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NB_L2; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    bank_q[b] <= 1'b0;
      else if (act_i == A_OFF)                        bank_q[b] <= 1'b0;
      else if (act_i == A_BANK && bank_i == BW'(b))   bank_q[b] <= 1'b1;
    end
  end

  always_comb begin
    pwr_ctl_o              = '0;
    pwr_ctl_o[NB_L2-1:0]   = bank_q;
    pwr_ctl_o[PB_TAG]      = mem_q;
    pwr_ctl_o[PB_ETB]      = mem_q;
    pwr_ctl_o[PB_STBY]     = mem_q;
    pwr_ctl_o[PB_SLPRET]   = mem_q;
    pwr_ctl_o[PB_CLAMP]    = clamp_q;
    pwr_ctl_o[PB_HS]       = hs_q;
    pwr_ctl_o[PB_LDO]      = ldo_q;
  end

  assign rst_ctl_o = rst_q;
  always_comb begin
    clk_ctl_o        = '0;
    clk_ctl_o[CB_EN] = clk_en_q;
  end
endmodule

// File: rtl/core_powerup_seq.sv
module core_powerup_seq #(
  parameter int NB_L2      = 3,
  parameter int SETTLE_CYC = 200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        pwrdn_i,
  output logic [2:0]  rst_ctl_o,
  output logic [1:0]  clk_ctl_o,
  output logic [22:0] pwr_ctl_o,
  output logic        done_o
);
  import pup_pkg::*;
  localparam int BW = (NB_L2 > 1) ? $clog2(NB_L2) : 1;

  logic          tmr_load, tmr_exp;
  act_e          act;
  logic [BW-1:0] bank;

  pup_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pwrdn_i),
    .load_i (tmr_load),
    .exp_o  (tmr_exp)
  );

  pup_fsm #(.NB_L2(NB_L2)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pwrdn_i    (pwrdn_i),
    .tmr_exp_i  (tmr_exp),
    .tmr_load_o (tmr_load),
    .act_o      (act),
    .bank_o     (bank),
    .done_o     (done_o)
  );

  pup_ctl_regs #(.NB_L2(NB_L2)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .bank_i    (bank),
    .rst_ctl_o (rst_ctl_o),
    .clk_ctl_o (clk_ctl_o),
    .pwr_ctl_o (pwr_ctl_o)
  );
endmodule

// File: rtl/core_powerup_seq_chk.sv
module core_powerup_seq_chk #(
  parameter int NB_L2 = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        pwrdn_i,
  input logic [2:0]  rst_ctl_o,
  input logic [1:0]  clk_ctl_o,
  input logic [22:0] pwr_ctl_o,
  input logic        done_o
);
  AST_BANK_ONE_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pwr_ctl_o[NB_L2-1:0] & ~$past(pwr_ctl_o[NB_L2-1:0]))); // R4

  for (genvar b = 0; b < NB_L2 - 1; b++) begin : g_ord
    AST_BANK_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_ctl_o[b] |-> pwr_ctl_o[b+1]); // R4
  end

  AST_MEM_AFTER_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_ctl_o[19] |-> (pwr_ctl_o[21] && pwr_ctl_o[22])); // R3

  AST_BANK_AFTER_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_ctl_o[NB_L2-1] |-> $past(pwr_ctl_o[16])); // R4

  AST_UNCLAMP_UNDER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_ctl_o[20]) |-> (rst_ctl_o[1] && pwr_ctl_o[0])); // R5

  AST_CLK_AFTER_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ctl_o[1] |-> (!rst_ctl_o[1] && !pwr_ctl_o[20])); // R6

  AST_BUS_RESET_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ctl_o[2]); // R6

  AST_DONE_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rst_ctl_o[0] && clk_ctl_o[1])); // R7

  AST_PWRDN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> (rst_ctl_o == 3'b111 && clk_ctl_o == 2'b00 &&
                 pwr_ctl_o == 23'h100000 && !done_o)); // R9

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pwrdn_i) |=> done_o); // R8
endmodule

bind core_powerup_seq core_powerup_seq_chk #(.NB_L2(NB_L2)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .pwrdn_i   (pwrdn_i),
  .rst_ctl_o (rst_ctl_o),
  .clk_ctl_o (clk_ctl_o),
  .pwr_ctl_o (pwr_ctl_o),
  .done_o    (done_o)
);

// File: tb/sim_core_powerup_seq.sv
`timescale 1ns/1ps
module sim_core_powerup_seq;
  localparam int NB  = 3;
  localparam int SET = 5;
  localparam logic [22:0] P_RST = 23'h100000;
  localparam logic [22:0] P_HS  = 23'h600000;
  localparam logic [22:0] P_MEM = 23'h0F0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pwrdn = 1'b0;
  logic [2:0]  rst_ctl;
  logic [1:0]  clk_ctl;
  logic [22:0] pwr_ctl;
  logic        done;

  always #2.5 clk = ~clk;

  core_powerup_seq #(.NB_L2(NB), .SETTLE_CYC(SET)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pwrdn_i(pwrdn),
    .rst_ctl_o(rst_ctl), .clk_ctl_o(clk_ctl), .pwr_ctl_o(pwr_ctl), .done_o(done)
  );

  typedef struct {
    logic [2:0]  r;
    logic [1:0]  c;
    logic [22:0] p;
    logic        d;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [2:0]  m_r;
  logic [1:0]  m_c;
  logic [22:0] m_p;
  logic        m_d;
  int ph, wcnt, bk;

  task automatic model_reset();
    m_r = 3'b111; m_c = 2'b00; m_p = P_RST; m_d = 1'b0; ph = 0; wcnt = 0; bk = 0;
  endtask

  task automatic cyc(bit st, bit pd);
    exp_t e;
    string tg;
    @(negedge clk);
    start = st; pwrdn = pd;
    tg = "R1";
    if (pd) begin
      model_reset();
      tg = "R9";
    end else begin
      case (ph)
        0: if (st) begin m_r = 3'b111; ph = 1; tg = "R2"; end
        1: begin m_p |= P_HS; ph = 2; wcnt = 0; tg = "R2"; end
        2: begin
          tg = "R3";
          if (wcnt == SET - 1) begin m_p |= P_MEM; ph = 3; bk = NB - 1; end
          else wcnt++;
        end
        3: begin
          tg = "R4";
          m_p[bk] = 1'b1;
          if (bk == 0) ph = 4; else bk--;
        end
        4: begin m_p[20] = 1'b0; ph = 5; tg = "R5"; end
        5: begin m_r[1] = 1'b0; ph = 6; tg = "R6"; end
        6: begin m_c[1] = 1'b1; ph = 7; tg = "R6"; end
        7: begin m_r[0] = 1'b0; m_d = 1'b1; ph = 8; tg = "R7"; end
        default: tg = "R7";
      endcase
      if (st && ph != 1) tg = "R8";
    end
    e.r = m_r; e.c = m_c; e.p = m_p; e.d = m_d; e.tag = tg;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
  endtask

  // monitor: compare each expected item after the edge it belongs to
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if ({rst_ctl, clk_ctl, pwr_ctl, done} !== {e.r, e.c, e.p, e.d}) begin
        n_fail++;
        $display("FAIL %s: got r=%b c=%b p=%h d=%b, expected r=%b c=%b p=%h d=%b",
                 e.tag, rst_ctl, clk_ctl, pwr_ctl, done, e.r, e.c, e.p, e.d);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    #12;
    @(negedge clk);
    n_chk++;
    if ({rst_ctl, clk_ctl, pwr_ctl, done} !== {3'b111, 2'b00, P_RST, 1'b0}) begin
      n_fail++;
      $display("FAIL R1: got r=%b c=%b p=%h d=%b, expected reset values",
               rst_ctl, clk_ctl, pwr_ctl, done);
    end
    rst_n = 1'b1;
    idle(3);                           // R1 idle hold
    cyc(1'b1, 1'b0); idle(SET + 12);   // R2..R7 clean run
    cyc(1'b1, 1'b0); idle(2);          // R8 start after done
    cyc(1'b0, 1'b1); idle(2);          // R9 pwrdn from done
    cyc(1'b1, 1'b0); idle(3);          // restart, into settle
    cyc(1'b0, 1'b1); idle(2);          // R9 pwrdn mid-settle
    cyc(1'b1, 1'b0);                   // R8 start pulses mid-sequence
    for (int i = 0; i < SET + 10; i++) cyc(i[0], 1'b0);
    cyc(1'b1, 1'b1); idle(2);          // R9 priority over start
    cyc(1'b1, 1'b0); idle(SET + 12);   // full rerun after power-down
    wait (sb.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule